// File: doc/BRIEF.md
# Shared Store/Busy Line Controller

This block runs the handshake on an open-drain line that several memory devices share, up to 32 of them. The line does two jobs. Any agent can pull it low to ask for a hardware store into nonvolatile cells. Each device holds it low while its own store is running, so the line also reads as busy. The controller senses the line through a two-stage synchroniser. It filters short low glitches. Once a request is accepted, it lets in-flight SRAM accesses finish during a grace window.

Whether a requested store actually runs depends on two inputs: the write-since-store flag and the low-voltage inhibit flag. When a store runs, the only thing the block ever drives is a pull-down enable. It never drives the line high. After any store, and after any refused hardware request, the controller holds the device in standby until the shared line is seen high again. A software store request is also accepted. It ignores the write-since-store flag but obeys the low-voltage inhibit.

Top module: `busyline_ctrl`

## Requirements
- R1: A low on the sensed line counts as a hardware store request only after the synchronised level has been low for MIN_PULSE consecutive cycles. A low of MIN_PULSE-1 cycles produces no `store_go`, no `hold_off` and no `pull_dn`. With `acc_evt` held high, `store_go` appears exactly MIN_PULSE+3 cycles after the line goes low.
- R2: After a request is accepted, a grace window of up to GRACE cycles follows. Any access event (`acc_evt`=1) during the window starts the store on the next edge. Without such an event, the store starts GRACE-1 cycles later than with one.
- R3: `wr_ok` follows `wr_req` only while the synchronised line is high and no store or standby is active. A write attempted while the line is low is refused (`wr_ok`=0).
- R4: A hardware request with `dirty`=0 starts no store. `hold_off` is then 1 until the line is seen high again.
- R5: `store_go` is a one-cycle pulse in the first cycle of a store. `pull_dn` is 1 from that cycle until the cycle after `xfer_done` is sampled, and 0 at all other times.
- R6: After a store completes, `hold_off` stays 1 for as long as the synchronised line stays low. It falls within three cycles after the line is actually high.
- R7: While `lowv`=1, neither a hardware request nor `sw_req` starts a store.
- R8: A one-cycle `sw_req` with `lowv`=0 starts a store on the next edge, whatever the value of `dirty`.
- R9: After reset, `pull_dn`, `store_go`, `hold_off` are 0, and `wr_ok` follows `wr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sensed level of the shared open-drain line (asynchronous) |
| acc_evt | input | 1 | Any address or control transition on the SRAM port this cycle |
| wr_req | input | 1 | SRAM write attempt |
| dirty | input | 1 | A write has occurred since the last store |
| lowv | input | 1 | Hold-up voltage below threshold |
| sw_req | input | 1 | Software store request, one-cycle pulse |
| xfer_done | input | 1 | Nonvolatile transfer finished |
| pull_dn | output | 1 | Enable for the line's pull-down driver |
| store_go | output | 1 | Start pulse for the nonvolatile transfer |
| hold_off | output | 1 | Standby/inhibit of SRAM operation |
| wr_ok | output | 1 | Write enable passed to the SRAM array |

## Verification
The assertions take for granted two things about the inputs. `xfer_done` comes only while a store is in progress, and `sw_req` is a single-cycle pulse given while the controller is idle. The stimulus keeps to this. `xfer_done` is raised only after `pull_dn` has been observed high, and software pulses are issued only after `hold_off` has been seen low. The shared line is modelled in the bench as a wired-AND of the external pull-down and the block's own `pull_dn`. Because of this, the release behaviour is exercised against a line that the block itself holds low.

// File: rtl/busyline_pkg.sv
package busyline_pkg;

    typedef enum logic [2:0] {
        BL_IDLE  = 3'd0,
        BL_QUAL  = 3'd1,
        BL_GRACE = 3'd2,
        BL_STORE = 3'd3,
        BL_WAITH = 3'd4
    } bl_state_e;

    typedef struct packed {
        logic pull_dn;
        logic hold_off;
        logic accept;
    } bl_ctl_t;

    function automatic int bl_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic bl_ctl_t bl_decode(input bl_state_e s);
        bl_ctl_t c;
        c.pull_dn  = (s == BL_STORE);
        c.hold_off = (s == BL_STORE) || (s == BL_WAITH);
        c.accept   = (s == BL_IDLE);
        return c;
    endfunction

endpackage

// File: rtl/busyline_sync.sv
module busyline_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/busyline_fsm.sv
module busyline_fsm
    import busyline_pkg::*;
#(
    parameter int MIN_PULSE = 4,
    parameter int GRACE     = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_s,
    input  logic      acc_evt,
    input  logic      dirty,
    input  logic      lowv,
    input  logic      sw_req,
    input  logic      xfer_done,
    output bl_state_e state,
    output logic      store_go
);
    localparam int CW = $clog2(bl_max(MIN_PULSE, GRACE) + 1);
    localparam logic [CW-1:0] MIN_LAST   = CW'(MIN_PULSE - 1);
    localparam logic [CW-1:0] GRACE_LAST = CW'(GRACE - 1);

    bl_state_e st, nxt;
    logic [CW-1:0] cnt, cnt_n;
    logic go_n;

    always_comb begin
        nxt   = st;
        cnt_n = cnt;
        go_n  = 1'b0;
        case (st)
            BL_IDLE: begin
                if (sw_req && !lowv) begin
                    nxt  = BL_STORE;
                    go_n = 1'b1;
                end else if (!line_s) begin
                    nxt   = BL_QUAL;
                    cnt_n = CW'(1);
                end
            end
            BL_QUAL: begin
                if (line_s) begin
                    nxt = BL_IDLE;
                end else if (cnt >= MIN_LAST) begin
                    if (lowv || !dirty) begin
                        nxt = BL_WAITH;
                    end else begin
                        nxt   = BL_GRACE;
                        cnt_n = '0;
                    end
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            BL_GRACE: begin
                if (lowv) begin
                    nxt = BL_WAITH;
                end else if (acc_evt || cnt >= GRACE_LAST) begin
                    nxt  = BL_STORE;
                    go_n = 1'b1;
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            BL_STORE: if (xfer_done) nxt = BL_WAITH;
            BL_WAITH: if (line_s)    nxt = BL_IDLE;
            default:  nxt = BL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= BL_IDLE;
            cnt      <= '0;
            store_go <= 1'b0;
        end else begin
            st       <= nxt;
            cnt      <= cnt_n;
            store_go <= go_n;
        end
    end

    assign state = st;

    // R7: no store starts while the voltage inhibit was present
    a_r7_no_store_low_voltage: assert property (@(posedge clk) disable iff (rst)
        store_go |-> !$past(lowv));
    // R5: the start pulse lies inside the store
    a_r5_go_in_store: assert property (@(posedge clk) disable iff (rst)
        store_go |-> (st == BL_STORE));
    // R5: the store ends only on a transfer-done
    a_r5_end_on_done: assert property (@(posedge clk) disable iff (rst)
        (st == BL_STORE && !xfer_done) |=> (st == BL_STORE));
    // R6: standby holds while the line is low
    a_r6_wait_high: assert property (@(posedge clk) disable iff (rst)
        (st == BL_WAITH && !line_s) |=> (st == BL_WAITH));
    // R4: a hardware store starts only with the write-since-store flag set
    a_r4_dirty_needed: assert property (@(posedge clk) disable iff (rst)
        (st == BL_QUAL && !dirty) |=> (st != BL_GRACE));
endmodule

// File: rtl/busyline_gate.sv
module busyline_gate
    import busyline_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bl_state_e state,
    input  logic      line_s,
    input  logic      wr_req,
    output logic      pull_dn,
    output logic      hold_off,
    output logic      wr_ok
);
    bl_ctl_t ctl;

    always_comb ctl = bl_decode(state);

    assign pull_dn  = ctl.pull_dn;
    assign hold_off = ctl.hold_off;
    assign wr_ok    = wr_req && line_s && ctl.accept;

    // R3: no write passes while the line is low
    a_r3_no_write_low: assert property (@(posedge clk) disable iff (rst)
        wr_ok |-> line_s);
    // R3: no write passes during standby
    a_r3_no_write_standby: assert property (@(posedge clk) disable iff (rst)
        wr_ok |-> !hold_off);
    // R6: standby is released only after the line is seen high
    a_r6_release_high: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_off) |-> $past(line_s));
endmodule

// File: rtl/busyline_ctrl.sv
module busyline_ctrl #(
    parameter int MIN_PULSE   = 4,
    parameter int GRACE       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic acc_evt,
    input  logic wr_req,
    input  logic dirty,
    input  logic lowv,
    input  logic sw_req,
    input  logic xfer_done,
    output logic pull_dn,
    output logic store_go,
    output logic hold_off,
    output logic wr_ok
);
    import busyline_pkg::*;

    logic      line_s;
    bl_state_e state;

    busyline_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(line_in), .d_out(line_s)
    );

    busyline_fsm #(.MIN_PULSE(MIN_PULSE), .GRACE(GRACE)) u_fsm (
        .clk(clk), .rst(rst), .line_s(line_s), .acc_evt(acc_evt),
        .dirty(dirty), .lowv(lowv), .sw_req(sw_req),
        .xfer_done(xfer_done), .state(state), .store_go(store_go)
    );

    busyline_gate u_gate (
        .clk(clk), .rst(rst), .state(state), .line_s(line_s),
        .wr_req(wr_req), .pull_dn(pull_dn), .hold_off(hold_off),
        .wr_ok(wr_ok)
    );

    // R5: the pull-down is released only after transfer-done
    a_r5_release_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(pull_dn) |-> $past(xfer_done));
    // R5: a start pulse always comes with the pull-down
    a_r5_go_pulls: assert property (@(posedge clk) disable iff (rst)
        store_go |-> pull_dn);
endmodule

// File: tb/busyline_ctrl_test.sv
module busyline_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int MINP = 4;
    localparam int GRC  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0;
    logic acc_evt = 1'b0, wr_req = 1'b0, dirty = 1'b0, lowv = 1'b0;
    logic sw_req = 1'b0, xfer_done = 1'b0;
    logic pull_dn, store_go, hold_off, wr_ok;
    logic line_in;

    int n_chk = 0, n_err = 0, n_go = 0, go_base = 0;
    int exp_q[$];
    bit done = 1'b0;

    assign line_in = ~(ext_low | pull_dn);

    always #(CLK_PERIOD/2) clk = ~clk;

    busyline_ctrl #(.MIN_PULSE(MINP), .GRACE(GRC)) uut (
        .clk(clk), .rst(rst), .line_in(line_in), .acc_evt(acc_evt),
        .wr_req(wr_req), .dirty(dirty), .lowv(lowv), .sw_req(sw_req),
        .xfer_done(xfer_done), .pull_dn(pull_dn), .store_go(store_go),
        .hold_off(hold_off), .wr_ok(wr_ok)
    );

    // monitor: counts store start pulses away from the edge
    always @(negedge clk) if (!rst && store_go) n_go++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver side: queue the expected number of store starts for a scenario
    task automatic sb_expect(input int n);
        exp_q.push_back(n);
        go_base = n_go;
    endtask

    task automatic sb_pop(input string tag);
        int e;
        e = exp_q.pop_front();
        check((n_go - go_base) == e, tag, n_go - go_base, e);
    endtask

    task automatic wait_go(output int k);
        k = 0;
        while (k < 60) begin
            @(negedge clk);
            k++;
            if (store_go) break;
        end
    endtask

    task automatic finish_store();
        xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    endtask

    initial begin
        int lat_evt, lat_no;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R9 reset state
        check(pull_dn == 0, "R9 pull_dn", pull_dn, 0);
        check(store_go == 0, "R9 store_go", store_go, 0);
        check(hold_off == 0, "R9 hold_off", hold_off, 0);
        wr_req = 1'b1; #1;
        check(wr_ok == 1, "R9 wr_ok idle", wr_ok, 1);
        wr_req = 1'b0;

        // R1 short pulse MIN-1 cycles
        dirty = 1'b1;
        sb_expect(0);
        ext_low = 1'b1; tick(MINP-1); ext_low = 1'b0;
        tick(3);
        check(hold_off == 0, "R1 short pulse hold_off", hold_off, 0);
        tick(5);
        sb_pop("R1 short pulse no store");

        // R1/R2/R3 with access event
        sb_expect(1);
        acc_evt = 1'b1;
        ext_low = 1'b1;
        tick(3);
        wr_req = 1'b1; #1;
        check(wr_ok == 0, "R3 write while line low", wr_ok, 0);
        wr_req = 1'b0;
        wait_go(lat_evt);
        lat_evt += 3;
        acc_evt = 1'b0;
        check(lat_evt == MINP+3, "R1 latency with event", lat_evt, MINP+3);
        check(pull_dn == 1, "R5 pull_dn in store", pull_dn, 1);
        ext_low = 1'b0;
        tick(3);
        check(pull_dn == 1, "R5 pull_dn held", pull_dn, 1);
        check(store_go == 0, "R5 go one cycle", store_go, 0);
        finish_store();
        check(pull_dn == 0, "R5 release after done", pull_dn, 0);
        check(hold_off == 1, "R6 standby after store", hold_off, 1);
        tick(3);
        check(hold_off == 0, "R6 standby released", hold_off, 0);
        sb_pop("R2 one store");

        // R2 without access event: grace runs out
        sb_expect(1);
        ext_low = 1'b1;
        wait_go(lat_no);
        check(lat_no == MINP+3+GRC-1, "R2 grace length", lat_no, MINP+3+GRC-1);
        // R6 line kept low by another agent
        tick(2);
        finish_store();
        tick(6);
        check(hold_off == 1, "R6 held while line low", hold_off, 1);
        ext_low = 1'b0;
        tick(3);
        check(hold_off == 0, "R6 released on high", hold_off, 0);
        sb_pop("R2 store after grace");

        // R4 not dirty
        dirty = 1'b0;
        sb_expect(0);
        ext_low = 1'b1; tick(12);
        check(hold_off == 1, "R4 standby without store", hold_off, 1);
        check(pull_dn == 0, "R4 no pull", pull_dn, 0);
        ext_low = 1'b0; tick(3);
        check(hold_off == 0, "R4 released", hold_off, 0);
        sb_pop("R4 no store when clean");

        // R7 low voltage inhibit
        dirty = 1'b1; lowv = 1'b1;
        sb_expect(0);
        ext_low = 1'b1; tick(15);
        check(pull_dn == 0, "R7 hw inhibited", pull_dn, 0);
        ext_low = 1'b0; tick(4);
        check(hold_off == 0, "R7 idle again", hold_off, 0);
        sw_req = 1'b1; tick(1); sw_req = 1'b0;
        tick(2);
        check(pull_dn == 0, "R7 sw inhibited", pull_dn, 0);
        sb_pop("R7 no store");

        // R8 software store while clean
        lowv = 1'b0; dirty = 1'b0;
        sb_expect(1);
        sw_req = 1'b1; tick(1); sw_req = 1'b0;
        check(store_go == 1, "R8 sw go", store_go, 1);
        check(pull_dn == 1, "R8 sw pull", pull_dn, 1);
        tick(2);
        finish_store();
        tick(4);
        check(hold_off == 0, "R8 back to idle", hold_off, 0);
        sb_pop("R8 one store");

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule